// File: doc/BRIEF.md
# Page-Register Address Translator

This block sits between a processor and memory and turns a 16-bit byte address issued by a program into an 18-bit physical address. The three most significant address bits pick one of eight page registers inside the block. The selected register supplies a 5-bit frame number, and that frame number takes the place of the page bits in the outgoing address. The low 13 bits, the byte-in-page offset, pass through unchanged. Translation is combinational: the physical address and the trap request are valid in the same cycle as the incoming address.

Each page register also holds three access-right bits: read, write and execute. With every address the processor states its intended use, which is one of read, write or instruction fetch. If the selected page does not grant that use, the block raises a trap request. While the trap request is high, the physical address must be treated as meaningless.

System software fills the page registers through a simple write port, in the same way it writes a peripheral's registers. Each write lands on a clock edge. Reset clears every register, so all pages have no rights and every access traps until software loads the table.

Top module: `page_mmu`

## Requirements
- R1: When `trap` is low, `pa[17:13]` equals the frame number held by the page register selected by `va[15:13]`.
- R2: `pa[12:0]` always equals `va[12:0]`.
- R3: The rights field is `{R,W,X}`, with R in bit 2, W in bit 1 and X in bit 0. Access code 00 (read) needs R, code 01 (write) needs W, and code 10 (fetch) needs X. `trap` is high exactly when the required bit of the selected page is clear.
- R4: Access code 11 is reserved and always raises `trap`, whatever the rights are.
- R5: A synchronous reset (`rst_n` low at a rising edge) clears every page register to frame 0 with no rights. After reset, every access to every page traps.
- R6: A load (`ld_en` high at a rising edge) writes `ld_frame` and `ld_perm` into the register selected by `ld_idx`. The new value appears on the outputs from that edge onward, and before the edge the outputs still reflect the old value.
- R7: A load leaves every other page register unchanged.
- R8: The four common rights settings behave as follows. Read-write (110) allows read and write but not fetch. Read-only (100) allows read only. Execute-only (001) allows fetch only. Read-execute (101) allows read and fetch but not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| va | input | 16 | Virtual byte address from the processor |
| acc | input | 2 | Intended use: 00 read, 01 write, 10 fetch, 11 reserved |
| pa | output | 18 | Physical address: frame number above the 13-bit offset |
| trap | output | 1 | Access-violation trap request |
| ld_en | input | 1 | Page-register load strobe |
| ld_idx | input | 3 | Page register to load |
| ld_frame | input | 5 | Frame number to store |
| ld_perm | input | 3 | Rights to store, {R,W,X} |

## Verification
The bench builds the block with its default parameters: 3 page bits, a 5-bit frame field and a 16-bit virtual address. With these values all eight page registers and every access code can be visited exhaustively, as can every one of the eight possible rights settings. Offsets at both ends of a page, 0 and 0x1FFF, are driven so that a slip of one bit between the page field and the offset field shows up in the physical address. The full 5-bit frame range, including frame 31, comes within reach, so the widened high physical bits are exercised.

// File: rtl/mmu_pkg.sv
// Shared types for the page-register translator.
// Assumes a three-bit rights field and a two-bit access code.
package mmu_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_t;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

endpackage

// File: rtl/mmu_page_regs.sv
// Page register file: one frame number and one rights field per page.
// Loaded one entry per clock through a write strobe; read combinationally.
// Assumes a synchronous active-low reset that clears every entry.
module mmu_page_regs #(
    parameter int PAGE_BITS = 3,
    parameter int FRAME_W   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [PAGE_BITS-1:0] ld_idx,
    input  logic [FRAME_W-1:0]   ld_frame,
    input  mmu_pkg::perm_t       ld_perm,
    input  logic [PAGE_BITS-1:0] rd_idx,
    output logic [FRAME_W-1:0]   rd_frame,
    output mmu_pkg::perm_t       rd_perm
);
    import mmu_pkg::*;

    localparam int NUM_PAGES = 1 << PAGE_BITS;

    logic [FRAME_W-1:0] frame_q [NUM_PAGES];
    perm_t              perm_q  [NUM_PAGES];

    for (genvar i = 0; i < NUM_PAGES; i++) begin : g_entry
        // Hold or reload one entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frame_q[i] <= '0;
                perm_q[i]  <= '0;
            end else if (ld_en && (ld_idx == PAGE_BITS'(i))) begin
                frame_q[i] <= ld_frame;
                perm_q[i]  <= ld_perm;
            end
        end

        // R7
        others_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(ld_en && (ld_idx == PAGE_BITS'(i))) |=>
                ($stable(frame_q[i]) && $stable(perm_q[i])));
    end

    // Select the entry for the current page
    always_comb begin
        rd_frame = frame_q[rd_idx];
        rd_perm  = perm_q[rd_idx];
    end

    // R6
    load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (frame_q[$past(ld_idx)] == $past(ld_frame)) &&
                  (perm_q[$past(ld_idx)] == $past(ld_perm)));

endmodule

// File: rtl/mmu_perm_check.sv
// Rights checker: compares the proposed use with the page's rights.
// Purely combinational; the clock only serves the local assertions.
module mmu_perm_check (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     acc,
    input  mmu_pkg::perm_t perm,
    output logic           trap
);
    import mmu_pkg::*;

    // Pick the right the access needs and flag its absence
    always_comb begin
        case (acc_t'(acc))
            ACC_READ:  trap = !perm.r;
            ACC_WRITE: trap = !perm.w;
            ACC_FETCH: trap = !perm.x;
            default:   trap = 1'b1;
        endcase
    end

    // R4
    reserved_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == 2'b11) |-> trap);

    // R3
    no_rights_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perm == 3'b000) |-> trap);

endmodule

// File: rtl/page_mmu.sv
// Top of the translator: splits the virtual address into page and offset,
// looks up the page register, splices in the frame and checks rights.
// Assumes the processor holds va/acc stable while it uses pa/trap.
module page_mmu #(
    parameter int VA_W      = 16,
    parameter int PAGE_BITS = 3,
    parameter int FRAME_W   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [VA_W-1:0]            va,
    input  logic [1:0]                 acc,
    output logic [FRAME_W+VA_W-PAGE_BITS-1:0] pa,
    output logic                       trap,
    input  logic                       ld_en,
    input  logic [PAGE_BITS-1:0]       ld_idx,
    input  logic [FRAME_W-1:0]         ld_frame,
    input  logic [2:0]                 ld_perm
);
    import mmu_pkg::*;

    localparam int OFFS_W = VA_W - PAGE_BITS;
    localparam int PA_W   = FRAME_W + OFFS_W;

    logic [PAGE_BITS-1:0] va_page;
    logic [OFFS_W-1:0]    va_offs;
    logic [FRAME_W-1:0]   sel_frame;
    perm_t                sel_perm;

    // Split the virtual address
    always_comb begin
        va_page = va[VA_W-1:OFFS_W];
        va_offs = va[OFFS_W-1:0];
    end

    mmu_page_regs #(
        .PAGE_BITS(PAGE_BITS),
        .FRAME_W  (FRAME_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_frame(ld_frame),
        .ld_perm (perm_t'(ld_perm)),
        .rd_idx  (va_page),
        .rd_frame(sel_frame),
        .rd_perm (sel_perm)
    );

    mmu_perm_check u_chk (
        .clk  (clk),
        .rst_n(rst_n),
        .acc  (acc),
        .perm (sel_perm),
        .trap (trap)
    );

    // Splice frame above the untouched offset
    always_comb begin
        pa = {sel_frame, va_offs};
    end

    // R5
    reset_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> trap);

    // R1
    frame_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (va_page != $past(ld_idx)) ||
                  (pa[PA_W-1:OFFS_W] == $past(ld_frame)));

endmodule

// File: tb/page_mmu_bench.sv
module page_mmu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] va = '0;
    logic [1:0]  acc = '0;
    logic [17:0] pa;
    logic        trap;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [4:0]  ld_frame = '0;
    logic [2:0]  ld_perm = '0;

    int n_vec = 0;
    int n_bad = 0;

    logic [4:0] m_frame [8];
    logic [2:0] m_perm  [8];

    always #2 clk = ~clk;

    page_mmu u_page_mmu (
        .clk(clk), .rst_n(rst_n), .va(va), .acc(acc), .pa(pa), .trap(trap),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_frame(ld_frame), .ld_perm(ld_perm)
    );

    function automatic logic model_trap(input logic [2:0] p, input logic [1:0] a);
        case (a)
            2'b00:   return !p[2];
            2'b01:   return !p[1];
            2'b10:   return !p[0];
            default: return 1'b1;
        endcase
    endfunction

    task automatic fail_if(input bit bad, input string req, input logic [31:0] got,
                           input logic [31:0] exp);
        n_vec++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Drive one access and compare with the model
    task automatic probe(input logic [15:0] v, input logic [1:0] a, input string req);
        logic et;
        @(negedge clk);
        va = v; acc = a;
        #1;
        et = model_trap(m_perm[v[15:13]], a);
        fail_if(trap !== et, req, 32'(trap), 32'(et));
        fail_if(pa[12:0] !== v[12:0], "R2", 32'(pa[12:0]), 32'(v[12:0]));
        if (!et)
            fail_if(pa[17:13] !== m_frame[v[15:13]], req, 32'(pa[17:13]),
                    32'(m_frame[v[15:13]]));
    endtask

    task automatic load(input logic [2:0] i, input logic [4:0] f, input logic [2:0] p);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = i; ld_frame = f; ld_perm = p;
        @(negedge clk);
        ld_en = 1'b0;
        m_frame[i] = f; m_perm[i] = p;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            m_frame[i] = '0; m_perm[i] = '0;
        end
    endtask

    // R5: every page and every access traps after reset
    task automatic t_reset();
        for (int pg = 0; pg < 8; pg++)
            for (int a = 0; a < 4; a++)
                probe({3'(pg), 13'h0ABC}, 2'(a), "R5");
    endtask

    // R1 R2: distinct frames, offset extremes
    task automatic t_translate();
        for (int pg = 0; pg < 8; pg++)
            load(3'(pg), 5'(31 - 3 * pg), 3'b111);
        for (int pg = 0; pg < 8; pg++) begin
            probe({3'(pg), 13'h0000}, 2'b00, "R1");
            probe({3'(pg), 13'h1FFF}, 2'b01, "R1");
            probe({3'(pg), 13'h1555}, 2'b10, "R1");
        end
    endtask

    // R3 R4: all rights settings against all access codes
    task automatic t_rights();
        for (int p = 0; p < 8; p++) begin
            load(3'd5, 5'(p + 9), 3'(p));
            for (int a = 0; a < 3; a++)
                probe({3'd5, 13'h0123}, 2'(a), "R3");
            probe({3'd5, 13'h0123}, 2'b11, "R4");
        end
    endtask

    // R8: named combinations on distinct pages
    task automatic t_combos();
        load(3'd0, 5'd3, 3'b110);
        load(3'd1, 5'd4, 3'b100);
        load(3'd2, 5'd5, 3'b001);
        load(3'd3, 5'd6, 3'b101);
        for (int pg = 0; pg < 4; pg++)
            for (int a = 0; a < 3; a++)
                probe({3'(pg), 13'h0040}, 2'(a), "R8");
    endtask

    // R6 R7: load timing and isolation
    task automatic t_load();
        logic [4:0] keep_f [8];
        load(3'd6, 5'd7, 3'b100);
        @(negedge clk);
        va = {3'd6, 13'h0010}; acc = 2'b00;
        ld_en = 1'b1; ld_idx = 3'd6; ld_frame = 5'd20; ld_perm = 3'b010;
        #1;
        fail_if(trap !== 1'b0, "R6", 32'(trap), 32'd0);
        fail_if(pa[17:13] !== 5'd7, "R6", 32'(pa[17:13]), 32'd7);
        @(negedge clk);
        ld_en = 1'b0;
        m_frame[6] = 5'd20; m_perm[6] = 3'b010;
        #1;
        fail_if(trap !== 1'b1, "R6", 32'(trap), 32'd1);
        probe({3'd6, 13'h0010}, 2'b01, "R6");
        for (int i = 0; i < 8; i++) keep_f[i] = m_frame[i];
        load(3'd2, 5'd30, 3'b111);
        for (int pg = 0; pg < 8; pg++) begin
            probe({3'(pg), 13'h0777}, 2'b00, "R7");
            probe({3'(pg), 13'h0777}, 2'b01, "R7");
        end
    endtask

    // R5: reset clears loaded entries
    task automatic t_rereset();
        load(3'd4, 5'd17, 3'b111);
        probe({3'd4, 13'h0001}, 2'b00, "R5");
        do_reset();
        for (int pg = 0; pg < 8; pg++)
            probe({3'(pg), 13'h1000}, 2'b00, "R5");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_frame[i] = '0; m_perm[i] = '0;
        end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_translate();
        t_rights();
        t_combos();
        t_load();
        t_rereset();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule